// File: doc/BRIEF.md
# PCI Initiator Completion and Termination Screen

This block sits between a master port on the internal system bus and the engine that runs cycles on PCI as initiator. Each request arrives with a byte count, a byte offset inside the 32-bit word, a burst flag and the address-space type of the PCI window it targets. A request that a nonmemory (I/O) window cannot carry, because it would spill past the current 32-bit word, is refused at once. It is answered with a transfer error, it is never handed to the PCI engine, and it raises no interrupt.

A request that passes the screen goes to the PCI engine. The block then waits for the single outcome code of that cycle. It converts the outcome into exactly one completion strobe on the internal bus. A normal cycle returns its read data unchanged. A master abort completes quietly and returns all-ones for a read. Reaching the retry limit and a target abort both complete with a transfer error.

The three abnormal outcomes also set sticky interrupt flags when their enables are set. The flags stay set until software clears them with a write-one-to-clear pulse, and a single interrupt line reports any flag whose enable is set.

Top module: `pci_term_handler`

## Requirements
- R1: With `win_mem_i`=0 (nonmemory window), a request is rejected when `req_burst_i`=1 or when `req_offset_i` + `req_size_i` + 1 > 4. The byte count is `req_size_i`+1 and the offset is counted in bytes within the 32-bit word. A rejected request never raises `pci_issue_o`, and `bus_err_o` pulses in the cycle after the request.
- R2: With `win_mem_i`=1, every request is issued (`pci_issue_o`=1 in the request cycle) whatever its size, offset or burst flag. A nonmemory request that stays inside its word is also issued.
- R3: Outcome code 0 (normal) gives `bus_done_o`=1 in the cycle after `pci_rsp_valid_i`. `bus_rdata_o` then equals `pci_rdata_i` for a read and 0 for a write.
- R4: Outcome code 1 (master abort) gives `bus_done_o` and no error. The read data is 0xFFFF_FFFF, and a write returns 0.
- R5: Outcome code 2 (retry limit reached) and code 3 (target abort) give `bus_err_o` in the cycle after the response, with `bus_rdata_o` = 0.
- R6: Each request gets exactly one of `bus_done_o` or `bus_err_o`, as a single-cycle pulse. The two are never high together.
- R7: Flag bit 0 records a master abort, bit 1 a retry limit and bit 2 a target abort. A bit is set only when the matching bit of `irq_en_i` is 1 in the response cycle. Rejected requests never set any flag.
- R8: Flags hold until cleared by a 1 in the matching bit of `irq_clr_i`. A flag being set and cleared in the same cycle ends set.
- R9: `irq_o` is 1 exactly when some flag is set and its `irq_en_i` bit is 1. It follows changes of `irq_en_i` in the same cycle.
- R10: While a transfer is outstanding, a new request is not issued and is otherwise ignored. A response with no transfer outstanding produces no strobe.
- R11: After reset `bus_done_o`, `bus_err_o`, `bus_rdata_o`, `irq_flags_o` and `irq_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present for one cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | Request is a 32-byte burst |
| req_size_i | input | 3 | Byte count minus one (1 to 8 bytes) |
| req_offset_i | input | 2 | Byte offset within the 32-bit word |
| win_mem_i | input | 1 | Window type: 1 memory, 0 nonmemory |
| pci_issue_o | output | 1 | Request handed to the PCI engine this cycle |
| pci_rsp_valid_i | input | 1 | PCI outcome valid |
| pci_rsp_code_i | input | 2 | 0 normal, 1 master abort, 2 retry limit, 3 target abort |
| pci_rdata_i | input | 32 | Read data from PCI |
| irq_en_i | input | 3 | Interrupt enables (bit0 MA, bit1 RL, bit2 TA) |
| irq_clr_i | input | 3 | Write-one-to-clear for the flags |
| bus_rdata_o | output | 32 | Completion read data |
| bus_done_o | output | 1 | Completion without error |
| bus_err_o | output | 1 | Completion with transfer error |
| irq_flags_o | output | 3 | Sticky interrupt flags |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench walks every offset-and-size edge of the nonmemory screen. Examples are a 4-byte access at offset 0 against offset 1, 3 bytes at offset 1 against offset 2, and 2 bytes at offset 2 against offset 3. A screen off by one byte would either error a legal access or pass one that crosses the word. A crossing request that would also master-abort is driven to show that a rejected transfer leaves the flags clear; a design that screened after issuing would raise a flag or drive `pci_issue_o`. Outcome cases cover a master abort that must return all-ones without error, an abort whose enable is off that must not set a flag, and a flag set in the same cycle as its clear. Stray requests and responses around an outstanding transfer catch a design that double-issues or emits a strobe with nothing pending.

// File: rtl/pth_pkg.sv
package pth_pkg;
    typedef enum logic [1:0] {
        OC_NORMAL      = 2'd0,
        OC_MABORT      = 2'd1,
        OC_RETRY_LIMIT = 2'd2,
        OC_TABORT      = 2'd3
    } outcome_e;

    localparam int IRQ_N     = 3;
    localparam int IRQ_MA    = 0;
    localparam int IRQ_RL    = 1;
    localparam int IRQ_TA    = 2;
endpackage

// File: rtl/pth_screen.sv
module pth_screen #(
    parameter int SIZE_W     = 3,
    parameter int OFF_W      = 2,
    parameter int WORD_BYTES = 4
) (
    input  logic              mem_space_i,
    input  logic              burst_i,
    input  logic [SIZE_W-1:0] size_m1_i,
    input  logic [OFF_W-1:0]  offset_i,
    output logic              legal_o
);
    localparam int SPAN_W = ((SIZE_W > OFF_W) ? SIZE_W : OFF_W) + 1;

    logic [SPAN_W-1:0] last_byte;
    logic              crosses;

    always_comb begin
        // index of the last byte touched, relative to the word start
        last_byte = SPAN_W'(size_m1_i) + SPAN_W'(offset_i);
        crosses   = (last_byte >= SPAN_W'(WORD_BYTES));
        legal_o   = mem_space_i | (~burst_i & ~crosses);
    end
endmodule

// File: rtl/pth_complete.sv
module pth_complete
    import pth_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        code_i,
    input  logic              is_write_i,
    input  logic [DATA_W-1:0] pci_rdata_i,
    output logic              is_err_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [IRQ_N-1:0]  evt_o
);
    outcome_e code;

    always_comb begin
        code     = outcome_e'(code_i);
        is_err_o = 1'b0;
        rdata_o  = '0;
        evt_o    = '0;
        case (code)
            OC_NORMAL: begin
                rdata_o = is_write_i ? '0 : pci_rdata_i;
            end
            OC_MABORT: begin
                rdata_o       = is_write_i ? '0 : '1;
                evt_o[IRQ_MA] = 1'b1;
            end
            OC_RETRY_LIMIT: begin
                is_err_o      = 1'b1;
                evt_o[IRQ_RL] = 1'b1;
            end
            default: begin
                is_err_o      = 1'b1;
                evt_o[IRQ_TA] = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pth_irq.sv
module pth_irq #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    logic [N-1:0] flags_d, flags_q;
    logic [N-1:0] set_w;

    always_comb begin
        set_w   = evt_i & en_i;
        // a new event takes precedence over a clear in the same cycle
        flags_d = (flags_q & ~clr_i) | set_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & en_i);
endmodule

// File: rtl/pci_term_handler.sv
module pci_term_handler
    import pth_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SIZE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_burst_i,
    input  logic [SIZE_W-1:0] req_size_i,
    input  logic [1:0]        req_offset_i,
    input  logic              win_mem_i,
    output logic              pci_issue_o,
    input  logic              pci_rsp_valid_i,
    input  logic [1:0]        pci_rsp_code_i,
    input  logic [DATA_W-1:0] pci_rdata_i,
    input  logic [IRQ_N-1:0]  irq_en_i,
    input  logic [IRQ_N-1:0]  irq_clr_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_done_o,
    output logic              bus_err_o,
    output logic [IRQ_N-1:0]  irq_flags_o,
    output logic              irq_o
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int OFF_W      = $clog2(WORD_BYTES);

    typedef struct packed {
        logic              busy;
        logic              write;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] rdata;
    } state_t;

    state_t st_d, st_q;

    logic              legal;
    logic              cmp_err;
    logic [DATA_W-1:0] cmp_rdata;
    logic [IRQ_N-1:0]  cmp_evt;
    logic [IRQ_N-1:0]  irq_evt;
    logic              issue;
    logic              rsp_take;
    logic              outstanding;

    pth_screen #(
        .SIZE_W    (SIZE_W),
        .OFF_W     (OFF_W),
        .WORD_BYTES(WORD_BYTES)
    ) u_screen (
        .mem_space_i(win_mem_i),
        .burst_i    (req_burst_i),
        .size_m1_i  (req_size_i),
        .offset_i   (req_offset_i[OFF_W-1:0]),
        .legal_o    (legal)
    );

    pth_complete #(
        .DATA_W(DATA_W)
    ) u_complete (
        .code_i     (pci_rsp_code_i),
        .is_write_i (st_q.write),
        .pci_rdata_i(pci_rdata_i),
        .is_err_o   (cmp_err),
        .rdata_o    (cmp_rdata),
        .evt_o      (cmp_evt)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        issue     = 1'b0;
        rsp_take  = 1'b0;
        if (!st_q.busy) begin
            if (req_valid_i) begin
                if (legal) begin
                    issue      = 1'b1;
                    st_d.busy  = 1'b1;
                    st_d.write = req_write_i;
                end else begin
                    st_d.err   = 1'b1;
                    st_d.rdata = '0;
                end
            end
        end else if (pci_rsp_valid_i) begin
            rsp_take   = 1'b1;
            st_d.busy  = 1'b0;
            st_d.done  = ~cmp_err;
            st_d.err   = cmp_err;
            st_d.rdata = cmp_rdata;
        end
        irq_evt = rsp_take ? cmp_evt : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    pth_irq #(
        .N(IRQ_N)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (irq_evt),
        .en_i   (irq_en_i),
        .clr_i  (irq_clr_i),
        .flags_o(irq_flags_o),
        .irq_o  (irq_o)
    );

    assign outstanding = st_q.busy;
    assign pci_issue_o = issue;
    assign bus_done_o  = st_q.done;
    assign bus_err_o   = st_q.err;
    assign bus_rdata_o = st_q.rdata;
endmodule

// File: rtl/pth_checker.sv
module pth_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid_i,
    input logic       outstanding,
    input logic       pci_issue_o,
    input logic       pci_rsp_valid_i,
    input logic [1:0] pci_rsp_code_i,
    input logic [2:0] irq_en_i,
    input logic [2:0] irq_clr_i,
    input logic       bus_done_o,
    input logic       bus_err_o,
    input logic [2:0] irq_flags_o
);
    p_one_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_done_o && bus_err_o));

    p_reject_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !outstanding && !pci_issue_o) |=> (bus_err_o && !bus_done_o));

    p_reject_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !outstanding && !pci_issue_o && irq_clr_i == 3'b000)
            |=> $stable(irq_flags_o));

    p_no_double_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pci_issue_o |-> !outstanding);

    p_mabort_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding && pci_rsp_valid_i && pci_rsp_code_i == 2'd1) |=> (bus_done_o && !bus_err_o));

    p_abort_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (outstanding && pci_rsp_valid_i && pci_rsp_code_i[1]) |=> (bus_err_o && !bus_done_o));

    p_idle_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!outstanding && !req_valid_i) |=> (!bus_done_o && !bus_err_o));

    p_flag_ma_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flags_o[0] ##1 irq_flags_o[0]) |-> $past(irq_en_i[0]));

    p_flag_rl_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flags_o[1] ##1 irq_flags_o[1]) |-> $past(irq_en_i[1]));

    p_flag_ta_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_flags_o[2] ##1 irq_flags_o[2]) |-> $past(irq_en_i[2]));
endmodule

bind pci_term_handler pth_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid_i    (req_valid_i),
    .outstanding    (outstanding),
    .pci_issue_o    (pci_issue_o),
    .pci_rsp_valid_i(pci_rsp_valid_i),
    .pci_rsp_code_i (pci_rsp_code_i),
    .irq_en_i       (irq_en_i),
    .irq_clr_i      (irq_clr_i),
    .bus_done_o     (bus_done_o),
    .bus_err_o      (bus_err_o),
    .irq_flags_o    (irq_flags_o)
);

// File: tb/sim_pci_term_handler.sv
module sim_pci_term_handler;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_write = 0, req_burst = 0, win_mem = 0;
    logic [2:0]  req_size = 0;
    logic [1:0]  req_offset = 0;
    logic        pci_issue;
    logic        rsp_valid = 0;
    logic [1:0]  rsp_code = 0;
    logic [31:0] rsp_data = 0;
    logic [2:0]  irq_en = 0, irq_clr = 0;
    logic [31:0] bus_rdata;
    logic        bus_done, bus_err, irq;
    logic [2:0]  irq_flags;

    int total = 0;
    int fails = 0;

    always #(PERIOD/2) clk = ~clk;

    pci_term_handler u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_burst_i(req_burst),
        .req_size_i(req_size), .req_offset_i(req_offset), .win_mem_i(win_mem),
        .pci_issue_o(pci_issue),
        .pci_rsp_valid_i(rsp_valid), .pci_rsp_code_i(rsp_code), .pci_rdata_i(rsp_data),
        .irq_en_i(irq_en), .irq_clr_i(irq_clr),
        .bus_rdata_o(bus_rdata), .bus_done_o(bus_done), .bus_err_o(bus_err),
        .irq_flags_o(irq_flags), .irq_o(irq)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        mem;
        logic        burst;
        logic [2:0]  sz;
        logic [1:0]  off;
        logic        wr;
        logic [1:0]  code;
        logic [2:0]  en;
        logic [31:0] din;
        logic        e_issue;
        logic        e_err;
        logic [31:0] e_rdata;
        logic [2:0]  e_flags;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // R3: memory read, normal
        '{4'd3, 1'b1, 1'b0, 3'd3, 2'd0, 1'b0, 2'd0, 3'd7, 32'hA5A5_0001, 1'b1, 1'b0, 32'hA5A5_0001, 3'b000},
        // R3: memory write, normal
        '{4'd3, 1'b1, 1'b0, 3'd3, 2'd0, 1'b1, 2'd0, 3'd7, 32'h0000_1234, 1'b1, 1'b0, 32'h0,         3'b000},
        // R4: read master abort, all ones, flag bit0
        '{4'd4, 1'b1, 1'b0, 3'd3, 2'd0, 1'b0, 2'd1, 3'd7, 32'h1111_2222, 1'b1, 1'b0, 32'hFFFF_FFFF, 3'b001},
        // R4: write master abort, enables off
        '{4'd4, 1'b1, 1'b0, 3'd3, 2'd0, 1'b1, 2'd1, 3'd0, 32'h1111_2222, 1'b1, 1'b0, 32'h0,         3'b000},
        // R5: retry limit
        '{4'd5, 1'b1, 1'b0, 3'd3, 2'd0, 1'b0, 2'd2, 3'd7, 32'h3333_4444, 1'b1, 1'b1, 32'h0,         3'b010},
        // R7: target abort with only bit1 enabled
        '{4'd7, 1'b1, 1'b0, 3'd3, 2'd0, 1'b0, 2'd3, 3'd2, 32'h3333_4444, 1'b1, 1'b1, 32'h0,         3'b000},
        // R5: target abort enabled
        '{4'd5, 1'b1, 1'b0, 3'd3, 2'd0, 1'b0, 2'd3, 3'd4, 32'h3333_4444, 1'b1, 1'b1, 32'h0,         3'b100},
        // R2: memory burst
        '{4'd2, 1'b1, 1'b1, 3'd7, 2'd0, 1'b0, 2'd0, 3'd7, 32'h600D_0007, 1'b1, 1'b0, 32'h600D_0007, 3'b000},
        // R2: memory 4 bytes at offset 3
        '{4'd2, 1'b1, 1'b0, 3'd3, 2'd3, 1'b0, 2'd0, 3'd7, 32'h600D_0008, 1'b1, 1'b0, 32'h600D_0008, 3'b000},
        // R1: nonmemory burst
        '{4'd1, 1'b0, 1'b1, 3'd3, 2'd0, 1'b0, 2'd0, 3'd7, 32'h0,         1'b0, 1'b1, 32'h0,         3'b000},
        // R1: nonmemory 8 bytes
        '{4'd1, 1'b0, 1'b0, 3'd7, 2'd0, 1'b0, 2'd0, 3'd7, 32'h0,         1'b0, 1'b1, 32'h0,         3'b000},
        // R1: nonmemory 4 bytes offset 1
        '{4'd1, 1'b0, 1'b0, 3'd3, 2'd1, 1'b0, 2'd0, 3'd7, 32'h0,         1'b0, 1'b1, 32'h0,         3'b000},
        // R2: nonmemory 4 bytes offset 0
        '{4'd2, 1'b0, 1'b0, 3'd3, 2'd0, 1'b0, 2'd0, 3'd7, 32'h1000_000C, 1'b1, 1'b0, 32'h1000_000C, 3'b000},
        // R1: nonmemory 3 bytes offset 2
        '{4'd1, 1'b0, 1'b0, 3'd2, 2'd2, 1'b0, 2'd0, 3'd7, 32'h0,         1'b0, 1'b1, 32'h0,         3'b000},
        // R2: nonmemory 3 bytes offset 1
        '{4'd2, 1'b0, 1'b0, 3'd2, 2'd1, 1'b0, 2'd0, 3'd7, 32'h1000_000E, 1'b1, 1'b0, 32'h1000_000E, 3'b000},
        // R1: nonmemory 2 bytes offset 3
        '{4'd1, 1'b0, 1'b0, 3'd1, 2'd3, 1'b0, 2'd0, 3'd7, 32'h0,         1'b0, 1'b1, 32'h0,         3'b000},
        // R2: nonmemory 2 bytes offset 2
        '{4'd2, 1'b0, 1'b0, 3'd1, 2'd2, 1'b0, 2'd0, 3'd7, 32'h1000_0010, 1'b1, 1'b0, 32'h1000_0010, 3'b000},
        // R2: nonmemory 1 byte offset 3
        '{4'd2, 1'b0, 1'b0, 3'd0, 2'd3, 1'b0, 2'd0, 3'd7, 32'h1000_0011, 1'b1, 1'b0, 32'h1000_0011, 3'b000},
        // R7: rejected crossing request that would master-abort sets no flag
        '{4'd7, 1'b0, 1'b0, 3'd3, 2'd1, 1'b0, 2'd1, 3'd7, 32'h0,         1'b0, 1'b1, 32'h0,         3'b000}
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic drive_req(input logic mem, input logic burst, input logic [2:0] sz,
                             input logic [1:0] off, input logic wr);
        req_valid  = 1'b1;
        win_mem    = mem;
        req_burst  = burst;
        req_size   = sz;
        req_offset = off;
        req_write  = wr;
    endtask

    task automatic clear_flags();
        @(negedge clk);
        irq_clr = 3'b111;
        @(negedge clk);
        irq_clr = 3'b000;
    endtask

    task automatic run_vec(input int i);
        vec_t v;
        string tag;
        v   = VECS[i];
        tag = $sformatf("R%0d vec%0d", v.rq, i);
        @(negedge clk);
        drive_req(v.mem, v.burst, v.sz, v.off, v.wr);
        #1;
        chk({tag, " issue"}, 32'(pci_issue), 32'(v.e_issue));
        if (v.e_issue) begin
            @(negedge clk);
            req_valid = 1'b0;
            rsp_valid = 1'b1;
            rsp_code  = v.code;
            rsp_data  = v.din;
            irq_en    = v.en;
            @(negedge clk);
            rsp_valid = 1'b0;
        end else begin
            irq_en = v.en;
            @(negedge clk);
            req_valid = 1'b0;
        end
        chk({tag, " done"}, 32'(bus_done), 32'(!v.e_err));
        chk({tag, " err"},  32'(bus_err),  32'(v.e_err));
        if (!v.e_err) chk({tag, " rdata"}, bus_rdata, v.e_rdata);
        chk({tag, " flags"}, 32'(irq_flags), 32'(v.e_flags));
        // R6: single pulse
        @(negedge clk);
        chk({tag, " R6 strobe low"}, 32'({bus_done, bus_err}), 32'h0);
        irq_en = 3'b000;
        clear_flags();
    endtask

    // legal memory read with the given outcome, enables and clear pulse in response cycle
    task automatic mem_xfer(input logic [1:0] code, input logic [2:0] en, input logic [2:0] clr);
        @(negedge clk);
        drive_req(1'b1, 1'b0, 3'd3, 2'd0, 1'b0);
        @(negedge clk);
        req_valid = 1'b0;
        rsp_valid = 1'b1;
        rsp_code  = code;
        rsp_data  = 32'hCAFE_0000;
        irq_en    = en;
        irq_clr   = clr;
        @(negedge clk);
        rsp_valid = 1'b0;
        irq_clr   = 3'b000;
    endtask

    initial begin
        #(PERIOD * 20000);
        total++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 done",  32'(bus_done), 32'h0);
        chk("R11 err",   32'(bus_err), 32'h0);
        chk("R11 rdata", bus_rdata, 32'h0);
        chk("R11 flags", 32'(irq_flags), 32'h0);
        chk("R11 irq",   32'(irq), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle issue", 32'(pci_issue), 32'h0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // R9 and R8: sticky flag and enable gating of the interrupt line
        mem_xfer(2'd1, 3'b001, 3'b000);
        chk("R9 irq on", 32'(irq), 32'h1);
        irq_en = 3'b000;
        #1;
        chk("R9 irq masked", 32'(irq), 32'h0);
        chk("R8 flag held", 32'(irq_flags), 32'h1);
        @(negedge clk);
        irq_clr = 3'b010;
        @(negedge clk);
        irq_clr = 3'b000;
        chk("R8 other clear", 32'(irq_flags), 32'h1);
        irq_en = 3'b001;
        #1;
        chk("R9 irq back", 32'(irq), 32'h1);
        irq_clr = 3'b001;
        @(negedge clk);
        irq_clr = 3'b000;
        chk("R8 cleared", 32'(irq_flags), 32'h0);
        chk("R9 irq off", 32'(irq), 32'h0);

        // R8: set wins over clear in the same cycle
        mem_xfer(2'd2, 3'b010, 3'b010);
        chk("R8 set wins", 32'(irq_flags), 32'h2);
        chk("R5 err", 32'(bus_err), 32'h1);
        irq_en = 3'b000;
        clear_flags();

        // R10: request while outstanding is ignored
        @(negedge clk);
        drive_req(1'b1, 1'b0, 3'd3, 2'd0, 1'b0);
        @(negedge clk);
        drive_req(1'b0, 1'b1, 3'd3, 2'd0, 1'b0);
        #1;
        chk("R10 no issue busy", 32'(pci_issue), 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 busy no strobe", 32'({bus_done, bus_err}), 32'h0);
        rsp_valid = 1'b1;
        rsp_code  = 2'd0;
        rsp_data  = 32'h0BAD_BEEF;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R3 done after busy", 32'(bus_done), 32'h1);
        chk("R3 rdata after busy", bus_rdata, 32'h0BAD_BEEF);
        // R10: response with nothing outstanding
        rsp_valid = 1'b1;
        rsp_code  = 2'd3;
        irq_en    = 3'b111;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk("R10 idle rsp strobe", 32'({bus_done, bus_err}), 32'h0);
        chk("R10 idle rsp flags", 32'(irq_flags), 32'h0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule